// File: doc/BRIEF.md
# Banked UART Register Front-End

This block sits between a peripheral bus and the data path of a 16550-style serial port. A small number of bus offsets are shared between several views, and an access-select bit held in the line-control register chooses the view. With the bit clear, offset 0 is the data port: a read takes the oldest received byte off the receive queue and a write hands a byte to the transmit queue. With the bit set, offsets 0 and 4 hold the low and high bytes of a 16-bit baud divisor.

The receive and transmit queues and the serial shift engines are outside this block. The block produces single-cycle pop and push strobes toward those queues. It passes through the error flags of the byte at the head of the receive queue, and it runs the divisor counter that turns the peripheral clock into a 16x oversampling tick. Bus reads are combinational: `bus_rdata` is valid during the cycle in which the read is presented. Queue strobes act at the clock edge that ends that cycle.

Top module: `uart_bank_regs`

## Requirements
- R1: With the access bit (line-control bit 7) at 0, a read at offset 0x00 from a non-empty receive queue returns the head byte masked to the character length in line-control bits 1:0 (00 = 5, 01 = 6, 10 = 7, 11 = 8 bits, upper bits zero). It asserts `rxq_pop` for exactly that one cycle.
- R2: A data read with the receive queue empty returns 0x00 and does not assert `rxq_pop`.
- R3: With the access bit at 0, a write at offset 0x00 asserts `txq_push` for that one cycle, with `txq_data` equal to the written byte.
- R4: A write at offset 0x00 never pops the receive queue, and a read at offset 0x00 never pushes the transmit queue.
- R5: With the access bit at 1, offset 0x00 reads and writes divisor bits 7:0 and offset 0x04 reads and writes divisor bits 15:8. Neither access asserts `rxq_pop` or `txq_push`, even with data waiting in the receive queue.
- R6: The line-control register at offset 0x0C is readable and writable and resets to 0x03. The divisor resets to 0x0001.
- R7: `baud_tick` is a single-cycle pulse whose period is exactly N clock cycles for a divisor N of 1 or more.
- R8: A divisor of 0x0000 gives the same tick rate as 0x0001, one tick every cycle.
- R9: A write to either divisor byte reloads the tick counter. The first tick after the write appears in the N-th cycle after the write edge, where N is the new divisor.
- R10: The line-status read at offset 0x14 returns bit 0 = receive data ready, bit 2 = parity error, bit 3 = framing error and bit 4 = break, with the other bits zero. The error bits describe the current head byte, are zero when the queue is empty, and change only when the head is popped. Reading line status does not pop.
- R11: A read at any other offset returns 0x00, and a write there changes no readable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access presented this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when no read |
| rxq_empty | input | 1 | Receive queue holds no byte |
| rxq_head | input | 8 | Oldest byte in the receive queue |
| rxq_perr | input | 1 | Parity error of the head byte |
| rxq_ferr | input | 1 | Framing error of the head byte |
| rxq_brk | input | 1 | Break condition on the head byte |
| rxq_pop | output | 1 | Remove the head byte at this edge |
| txq_push | output | 1 | Append `txq_data` at this edge |
| txq_data | output | 8 | Byte for the transmit queue |
| baud_tick | output | 1 | 16x oversampling pulse |

## Verification
The hardest case to reach from the ports is the pairing of status and data across pops. The error flags must follow the head and change only after the pop, while the character-length mask changes between reads. The stimulus preloads a modelled queue with three bytes that carry different flag combinations. It then interleaves line-status reads, data reads and line-control writes, so that each status read falls between two pops. A second case fills the queue while the access bit is set, to show that divisor accesses leave a waiting byte in place. The tick reload is checked by counting cycles from the divisor-write edge for several divisors.

// File: rtl/uart_bank_regs.sv
module uart_bank_regs #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rxq_empty,
  input  logic [7:0]        rxq_head,
  input  logic              rxq_perr,
  input  logic              rxq_ferr,
  input  logic              rxq_brk,
  output logic              rxq_pop,
  output logic              txq_push,
  output logic [7:0]        txq_data,
  output logic              baud_tick
);
  localparam logic [ADDR_W-1:0] OFS_DATA  = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] OFS_DIVHI = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] OFS_LCTL  = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] OFS_LSTAT = ADDR_W'(5'h14);
  localparam int DIV_W = 16;

  logic [7:0]       lctl;
  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] tick_cnt;

  wire bank_hi  = lctl[7];
  wire rd_en    = bus_sel && !bus_wr;
  wire wr_en    = bus_sel && bus_wr;
  wire at_data  = bus_addr == OFS_DATA;
  wire at_divhi = bus_addr == OFS_DIVHI;

  wire div_lo_wr = wr_en && bank_hi && at_data;
  wire div_hi_wr = wr_en && bank_hi && at_divhi;
  wire div_wr    = div_lo_wr || div_hi_wr;

  wire [DIV_W-1:0] div_next = {div_hi_wr ? bus_wdata : divisor[15:8],
                               div_lo_wr ? bus_wdata : divisor[7:0]};
  wire [DIV_W-1:0] eff_div  = (divisor == '0) ? DIV_W'(1) : divisor;
  wire [DIV_W-1:0] eff_next = (div_next == '0) ? DIV_W'(1) : div_next;

  wire [7:0] len_mask = 8'hFF >> (2'd3 - lctl[1:0]);
  wire [7:0] lstat    = rxq_empty ? 8'h00
                                  : {3'b000, rxq_brk, rxq_ferr, rxq_perr, 1'b0, 1'b1};

  assign rxq_pop   = rd_en && !bank_hi && at_data && !rxq_empty;
  assign txq_push  = wr_en && !bank_hi && at_data;
  assign txq_data  = bus_wdata;
  assign baud_tick = tick_cnt == DIV_W'(1);

  always_comb begin
    bus_rdata = 8'h00;
    if (rd_en) begin
      unique case (bus_addr)
        OFS_DATA:  bus_rdata = bank_hi ? divisor[7:0]
                             : (rxq_empty ? 8'h00 : (rxq_head & len_mask));
        OFS_DIVHI: bus_rdata = bank_hi ? divisor[15:8] : 8'h00;
        OFS_LCTL:  bus_rdata = lctl;
        OFS_LSTAT: bus_rdata = lstat;
        default:   bus_rdata = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lctl    <= 8'h03;
      divisor <= DIV_W'(1);
    end else begin
      if (wr_en && bus_addr == OFS_LCTL) lctl <= bus_wdata;
      if (div_wr) divisor <= div_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    tick_cnt <= DIV_W'(1);
    else if (div_wr)               tick_cnt <= eff_next;
    else if (tick_cnt <= DIV_W'(1)) tick_cnt <= eff_div;
    else                           tick_cnt <= tick_cnt - DIV_W'(1);
  end

  // R2
  empty_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_empty |-> !rxq_pop);

  // R4
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rxq_pop && txq_push));

  // R7
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && !div_wr && eff_div > DIV_W'(1)) |=> !baud_tick);

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_cnt != '0) && (tick_cnt <= eff_div || div_wr));

  // R5
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !div_wr |=> $stable(divisor));

  // R9
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> (tick_cnt == eff_div));
endmodule

// File: tb/tb_uart_bank_regs.sv
module tb_uart_bank_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rxq_pop, txq_push, baud_tick;
  logic [7:0] txq_data;

  logic [10:0] qmem [8];
  int qcnt = 0;
  wire        rxq_empty = (qcnt == 0);
  wire [7:0]  rxq_head  = qmem[0][7:0];
  wire        rxq_perr  = qmem[0][8];
  wire        rxq_ferr  = qmem[0][9];
  wire        rxq_brk   = qmem[0][10];

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  uart_bank_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxq_empty(rxq_empty), .rxq_head(rxq_head), .rxq_perr(rxq_perr),
    .rxq_ferr(rxq_ferr), .rxq_brk(rxq_brk), .rxq_pop(rxq_pop),
    .txq_push(txq_push), .txq_data(txq_data), .baud_tick(baud_tick));

  always @(posedge clk) begin
    if (rxq_pop && qcnt > 0) begin
      for (int i = 0; i < 7; i++) qmem[i] <= qmem[i+1];
      qcnt <= qcnt - 1;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // vector: wr, addr[4:0], wdata, exp_rdata, exp_push, exp_pop
  localparam int NV = 22;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 5'h14, 8'h00, 8'h01, 1'b0, 1'b0},
    {1'b0, 5'h00, 8'h00, 8'hA5, 1'b0, 1'b1},
    {1'b0, 5'h14, 8'h00, 8'h05, 1'b0, 1'b0},
    {1'b1, 5'h00, 8'h55, 8'h00, 1'b1, 1'b0},
    {1'b1, 5'h0C, 8'h02, 8'h00, 1'b0, 1'b0},
    {1'b0, 5'h0C, 8'h00, 8'h02, 1'b0, 1'b0},
    {1'b0, 5'h14, 8'h00, 8'h05, 1'b0, 1'b0},
    {1'b0, 5'h00, 8'h00, 8'h3C, 1'b0, 1'b1},
    {1'b0, 5'h14, 8'h00, 8'h19, 1'b0, 1'b0},
    {1'b1, 5'h0C, 8'h00, 8'h00, 1'b0, 1'b0},
    {1'b0, 5'h00, 8'h00, 8'h10, 1'b0, 1'b1},
    {1'b0, 5'h14, 8'h00, 8'h00, 1'b0, 1'b0},
    {1'b0, 5'h00, 8'h00, 8'h00, 1'b0, 1'b0},
    {1'b1, 5'h0C, 8'h83, 8'h00, 1'b0, 1'b0},
    {1'b0, 5'h00, 8'h00, 8'h01, 1'b0, 1'b0},
    {1'b0, 5'h04, 8'h00, 8'h00, 1'b0, 1'b0},
    {1'b1, 5'h00, 8'h34, 8'h00, 1'b0, 1'b0},
    {1'b1, 5'h04, 8'h12, 8'h00, 1'b0, 1'b0},
    {1'b0, 5'h00, 8'h00, 8'h34, 1'b0, 1'b0},
    {1'b0, 5'h04, 8'h00, 8'h12, 1'b0, 1'b0},
    {1'b1, 5'h08, 8'h77, 8'h00, 1'b0, 1'b0},
    {1'b0, 5'h08, 8'h00, 8'h00, 1'b0, 1'b0}
  };

  task automatic access(input logic wr, input logic [4:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output logic push, output logic pop,
                        output logic [7:0] pdata);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #2;
    rd = bus_rdata; push = txq_push; pop = rxq_pop; pdata = txq_data;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] r, p; logic ps, pp;
    access(1'b1, a, d, r, ps, pp, p);
  endtask

  task automatic tick_run(input int n, input string req);
    for (int k = 1; k <= 3 * n; k++) begin
      @(negedge clk); #2;
      check(req, {15'd0, baud_tick}, {15'd0, (k % n) == 0});
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd, pd; logic ps, pp;
    for (int i = 0; i < 8; i++) qmem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R6 reset state
    access(1'b0, 5'h0C, 8'h00, rd, ps, pp, pd);
    check("R6 lctl reset", {8'h0, rd}, 16'h0003);
    // R7 default divisor 1 -> tick every cycle
    tick_run(1, "R7 reset tick");

    qmem[0] = {3'b000, 8'hA5};
    qmem[1] = {3'b001, 8'hBC};
    qmem[2] = {3'b110, 8'hF0};
    qcnt = 3;

    // R1 R2 R3 R4 R5 R6 R10 R11 table walk
    for (int v = 0; v < NV; v++) begin
      access(VEC[v][23], VEC[v][22:18], VEC[v][17:10], rd, ps, pp, pd);
      check($sformatf("R1/R10/R5/R11 vec%0d rdata", v), {8'h0, rd}, {8'h0, VEC[v][9:2]});
      check($sformatf("R3/R4 vec%0d push", v), {15'h0, ps}, {15'h0, VEC[v][1]});
      check($sformatf("R2/R4 vec%0d pop", v), {15'h0, pp}, {15'h0, VEC[v][0]});
      if (VEC[v][1]) check("R3 push data", {8'h0, pd}, {8'h0, VEC[v][17:10]});
    end

    // R5 no pop with byte waiting while bank bit set
    qmem[0] = {3'b001, 8'h6E}; qcnt = 1;
    access(1'b0, 5'h00, 8'h00, rd, ps, pp, pd);
    check("R5 div lo read pop", {15'h0, pp}, 16'h0);
    access(1'b1, 5'h00, 8'h05, rd, ps, pp, pd);
    check("R5 div lo write push", {15'h0, ps}, 16'h0);
    check("R5 div lo write pop", {15'h0, pp}, 16'h0);
    // R9 reload after write of both bytes: divisor 0x0005
    wr_reg(5'h04, 8'h00);
    tick_run(5, "R9 R7 divisor 5");
    wr_reg(5'h00, 8'h03);
    tick_run(3, "R9 reload divisor 3");
    // R8 zero divisor
    wr_reg(5'h00, 8'h00);
    tick_run(1, "R8 divisor zero");
    access(1'b0, 5'h00, 8'h00, rd, ps, pp, pd);
    check("R8 divisor reads zero", {8'h0, rd}, 16'h0000);
    // R10 status still for waiting byte, R1 8-bit read pops it
    wr_reg(5'h0C, 8'h03);
    access(1'b0, 5'h14, 8'h00, rd, ps, pp, pd);
    check("R10 status waiting", {8'h0, rd}, 16'h0005);
    check("R10 status no pop", {15'h0, pp}, 16'h0);
    access(1'b0, 5'h00, 8'h00, rd, ps, pp, pd);
    check("R1 8-bit read", {8'h0, rd}, 16'h006E);
    check("R1 pop", {15'h0, pp}, 16'h0001);
    @(negedge clk);
    check("R1 single pop", {15'h0, rxq_pop}, 16'h0);
    check("R1 queue drained", qcnt[15:0], 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule